// File: doc/BRIEF.md
# Receive ring buffer packet writer

This block takes an incoming Ethernet frame as a byte stream, marked by start-of-frame and end-of-frame flags. It decides from the destination address whether the frame is kept. A kept frame is written into a circular receive ring inside a byte-addressed packet RAM, and the ring is built from 256-byte pages. Frame data begins four bytes into the current page. When the data reaches the limit page it wraps to the first page of the ring. Once the last data byte is stored, the block writes a four-byte header at the start of the current page. The header holds a status code, the page where the next frame will begin, and the stored length. The block then gives the new current page to the register that owns it, loads its receive status byte and pulses a receive interrupt.

The first six bytes of a frame are the destination address. They are held in a six-entry shift buffer and are not written until the filter has decided. After the decision every new byte pushes the oldest held byte into RAM. At the end of the frame the last six bytes are drained from the buffer, so each frame costs ten RAM write cycles after its final byte. The ring bounds, the current page, the filter controls and the station address come from registers outside the block.

The controller runs through seven states. IDLE waits for a start marker. HOLD collects the destination. STREAM writes an accepted frame as it arrives. DISCARD waits for the end of a rejected frame. DRAIN empties the shift buffer. HEADER writes the four header bytes. DONE publishes the page and the interrupt. The transitions are:
- IDLE to HOLD on a start marker while running.
- IDLE to DISCARD on a start marker while stopped.
- HOLD to STREAM on the sixth byte of an accepted frame.
- HOLD to DRAIN when that sixth byte also ends the frame.
- HOLD to DISCARD on a rejected sixth byte.
- HOLD to IDLE when the frame ends early.
- STREAM to DRAIN at the end of the frame.
- DISCARD to IDLE at the end of the frame.
- DRAIN to HEADER after six writes.
- HEADER to DONE after four writes.
- DONE to IDLE.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame whose start marker arrives while `stopped` is high is dropped. Dropping means no RAM write, no interrupt and no change to the status byte or the page.
- R2: With `cfg_promisc` high, every frame of at least six bytes is accepted, whatever its destination.
- R3: With `cfg_promisc` low, a destination of all ones (ff:ff:ff:ff:ff:ff) is accepted only when `cfg_bcast` is high.
- R4: With `cfg_promisc` low, any other destination is accepted if bit 0 of its first byte is 1 (group address) or if all six bytes equal `station_addr`. Byte 0 of `station_addr` is bits 7:0. Every other destination is dropped.
- R5: The data bytes of an accepted frame are written in order, starting at address cur_page*256+4 and rising by one each time. When the address reaches ring_limit*256, it continues at ring_first*256.
- R6: After the data, four header bytes are written at cur_page*256+0..3, in this order:
  - offset 0: the status code;
  - offset 1: the next page;
  - offset 2: the low byte of the stored length;
  - offset 3: the high byte of the stored length.
  The stored length is the frame length plus 4.
- R7: The next page is cur_page + floor((stored length + 4 + 255)/256). If that value is at or above ring_limit, (ring_limit − ring_first) is subtracted from it.
- R8: After the header, `page_we` is high for exactly one cycle with `page_nxt` set to the next page. In the same cycle `rx_irq` pulses for one cycle.
- R9: The status code is 0x01, with 0x20 ORed in (giving 0x21) when bit 0 of the destination's first byte is 1. `rx_status` takes this code when a frame is accepted and keeps its value when a frame is dropped.
- R10: A frame that ends before its sixth byte is dropped without any RAM write.
- R11: A start marker that arrives while the block is still handling an earlier frame is ignored, together with the bytes that follow it.
- R12: After reset `ram_we`, `page_we` and `rx_irq` are low and `rx_status` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | A frame byte is present this cycle |
| frm_sof | input | 1 | This byte is the first of a frame |
| frm_eof | input | 1 | This byte is the last of a frame |
| frm_data | input | 8 | Frame byte |
| ring_first | input | PAGE_W | First page of the receive ring |
| ring_limit | input | PAGE_W | Page one past the end of the ring |
| cur_page | input | PAGE_W | Page where the next frame is stored |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_bcast | input | 1 | Accept the all-ones destination |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| stopped | input | 1 | Controller is in the stopped state |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | PAGE_W+8 | Packet RAM byte address |
| ram_wdata | output | 8 | Packet RAM write data |
| page_we | output | 1 | Load `page_nxt` into the current-page register |
| page_nxt | output | PAGE_W | Updated current page |
| rx_status | output | 8 | Receive status byte |
| rx_irq | output | 1 | One-cycle receive-complete interrupt |

## Verification
The assertions hold on every cycle:
- every RAM write lands inside the ring;
- every published page lies inside the ring;
- the interrupt is a single-cycle pulse that follows a header write;
- the status byte holds one of the two legal codes right after a store.

The filter decisions, the exact addresses and byte values, the wrap across the limit page, the next-page arithmetic, short frames and ignored start markers are shown only by the bench's scenarios. The bench predicts every RAM write and compares them one by one as the writes appear.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_STREAM,
        ST_DISCARD,
        ST_DRAIN,
        ST_HEADER,
        ST_DONE
    } rxw_state_e;

    localparam int DA_BYTES   = 6;   // destination address length
    localparam int HDR_BYTES  = 4;   // per-frame ring header
    localparam int CRC_ALLOW  = 4;   // space reserved for the frame check word
    localparam int PAGE_BITS  = 8;   // 256-byte pages
    localparam int LEN_W      = 16;  // stored length width

    localparam logic [7:0] STAT_OK    = 8'h01;
    localparam logic [7:0] STAT_GROUP = 8'h20;

endpackage

// File: rtl/rxw_addr_filter.sv
module rxw_addr_filter #(
    parameter int NBYTES = 6
) (
    input  logic [8*NBYTES-1:0] dest,
    input  logic [8*NBYTES-1:0] station,
    input  logic                promisc,
    input  logic                bcast_en,
    output logic                accept,
    output logic                is_group
);

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_eq[b]   = (dest[8*b +: 8] == station[8*b +: 8]);
        assign byte_ones[b] = &dest[8*b +: 8];
    end

    logic all_ones;
    assign all_ones = &byte_ones;
    assign is_group = dest[0];

    always_comb begin
        if (promisc)       accept = 1'b1;
        else if (all_ones) accept = bcast_en;
        else if (is_group) accept = 1'b1;
        else               accept = &byte_eq;
    end

endmodule

// File: rtl/rxw_ring_math.sv
module rxw_ring_math
    import rxw_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W+PAGE_BITS-1:0] wptr,
    input  logic [PAGE_W-1:0]           ring_first,
    input  logic [PAGE_W-1:0]           ring_limit,
    input  logic [PAGE_W-1:0]           base_page,
    input  logic [LEN_W-1:0]            frame_len,
    output logic [PAGE_W+PAGE_BITS-1:0] wptr_adv,
    output logic [LEN_W-1:0]            stored_len,
    output logic [PAGE_W-1:0]           next_page
);

    localparam int AW  = PAGE_W + PAGE_BITS;
    localparam int SW  = LEN_W + 1;

    // write pointer step with wrap from the limit page to the first page
    logic [AW-1:0] inc;
    assign inc      = wptr + 1'b1;
    assign wptr_adv = (inc == {ring_limit, {PAGE_BITS{1'b0}}})
                      ? {ring_first, {PAGE_BITS{1'b0}}} : inc;

    // page count of the stored frame, including the check-word allowance
    logic [SW-1:0] pages;
    logic [SW-1:0] sum;
    logic [SW-1:0] span;

    assign stored_len = frame_len + LEN_W'(HDR_BYTES);
    assign pages = ({1'b0, stored_len} + SW'(CRC_ALLOW + (1 << PAGE_BITS) - 1)) >> PAGE_BITS;
    assign sum   = SW'(base_page) + pages;
    assign span  = SW'(ring_limit) - SW'(ring_first);
    assign next_page = PAGE_W'((sum >= SW'(ring_limit)) ? (sum - span) : sum);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxw_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid,
    input  logic                    frm_sof,
    input  logic                    frm_eof,
    input  logic [7:0]              frm_data,
    input  logic [PAGE_W-1:0]       ring_first,
    input  logic [PAGE_W-1:0]       ring_limit,
    input  logic [PAGE_W-1:0]       cur_page,
    input  logic                    cfg_promisc,
    input  logic                    cfg_bcast,
    input  logic [47:0]             station_addr,
    input  logic                    stopped,
    output logic                    ram_we,
    output logic [PAGE_W+7:0]       ram_addr,
    output logic [7:0]              ram_wdata,
    output logic                    page_we,
    output logic [PAGE_W-1:0]       page_nxt,
    output logic [7:0]              rx_status,
    output logic                    rx_irq
);

    localparam int AW = PAGE_W + PAGE_BITS;
    localparam logic [2:0] LAST_DA  = 3'(DA_BYTES - 1);
    localparam logic [2:0] LAST_HDR = 3'(HDR_BYTES - 1);

    rxw_state_e state, nstate;

    logic [7:0]        sh [DA_BYTES];
    logic [2:0]        cnt;
    logic [LEN_W-1:0]  len;
    logic [PAGE_W-1:0] base;
    logic [AW-1:0]     wptr;
    logic              grp;

    logic              flt_accept, flt_group;
    logic [AW-1:0]     wptr_adv;
    logic [LEN_W-1:0]  stored_len;
    logic [PAGE_W-1:0] next_page;
    logic [47:0]       dest;

    // destination seen on the sixth byte: five held bytes plus the live one
    assign dest = {frm_data, sh[5], sh[4], sh[3], sh[2], sh[1]};

    rxw_addr_filter #(.NBYTES(DA_BYTES)) u_filter (
        .dest     (dest),
        .station  (station_addr),
        .promisc  (cfg_promisc),
        .bcast_en (cfg_bcast),
        .accept   (flt_accept),
        .is_group (flt_group)
    );

    rxw_ring_math #(.PAGE_W(PAGE_W)) u_math (
        .wptr       (wptr),
        .ring_first (ring_first),
        .ring_limit (ring_limit),
        .base_page  (base),
        .frame_len  (len),
        .wptr_adv   (wptr_adv),
        .stored_len (stored_len),
        .next_page  (next_page)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (frm_valid && frm_sof && !frm_eof)
                    nstate = stopped ? ST_DISCARD : ST_HOLD;
            end
            ST_HOLD: begin
                if (frm_valid) begin
                    if (cnt == LAST_DA) begin
                        if (flt_accept) nstate = frm_eof ? ST_DRAIN : ST_STREAM;
                        else            nstate = frm_eof ? ST_IDLE  : ST_DISCARD;
                    end else if (frm_eof) begin
                        nstate = ST_IDLE;
                    end
                end
            end
            ST_STREAM: begin
                if (frm_valid && frm_eof) nstate = ST_DRAIN;
            end
            ST_DISCARD: begin
                if (frm_valid && frm_eof) nstate = ST_IDLE;
            end
            ST_DRAIN: begin
                if (cnt == LAST_DA) nstate = ST_HEADER;
            end
            ST_HEADER: begin
                if (cnt == LAST_HDR) nstate = ST_DONE;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DA_BYTES; i++) sh[i] <= 8'h00;
            cnt       <= '0;
            len       <= '0;
            base      <= '0;
            wptr      <= '0;
            grp       <= 1'b0;
            rx_status <= 8'h00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frm_valid && frm_sof) begin
                        for (int i = 0; i < DA_BYTES - 1; i++) sh[i] <= sh[i+1];
                        sh[DA_BYTES-1] <= frm_data;
                        len  <= LEN_W'(1);
                        cnt  <= 3'd1;
                        base <= cur_page;
                        wptr <= {cur_page, PAGE_BITS'(HDR_BYTES)};
                    end
                end
                ST_HOLD: begin
                    if (frm_valid) begin
                        for (int i = 0; i < DA_BYTES - 1; i++) sh[i] <= sh[i+1];
                        sh[DA_BYTES-1] <= frm_data;
                        len <= len + 1'b1;
                        if (cnt == LAST_DA) begin
                            cnt <= '0;
                            grp <= flt_group;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_STREAM: begin
                    if (frm_valid) begin
                        for (int i = 0; i < DA_BYTES - 1; i++) sh[i] <= sh[i+1];
                        sh[DA_BYTES-1] <= frm_data;
                        len  <= len + 1'b1;
                        wptr <= wptr_adv;
                    end
                end
                ST_DRAIN: begin
                    for (int i = 0; i < DA_BYTES - 1; i++) sh[i] <= sh[i+1];
                    sh[DA_BYTES-1] <= 8'h00;
                    wptr <= wptr_adv;
                    cnt  <= (cnt == LAST_DA) ? 3'd0 : cnt + 1'b1;
                end
                ST_HEADER: cnt <= cnt + 1'b1;
                ST_DONE:   rx_status <= STAT_OK | (grp ? STAT_GROUP : 8'h00);
                ST_DISCARD: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = wptr;
        ram_wdata = sh[0];
        page_we   = 1'b0;
        rx_irq    = 1'b0;
        page_nxt  = next_page;
        unique case (state)
            ST_STREAM: ram_we = frm_valid;
            ST_DRAIN:  ram_we = 1'b1;
            ST_HEADER: begin
                ram_we   = 1'b1;
                ram_addr = {base, PAGE_BITS'(cnt)};
                unique case (cnt[1:0])
                    2'd0:    ram_wdata = STAT_OK | (grp ? STAT_GROUP : 8'h00);
                    2'd1:    ram_wdata = 8'(next_page);
                    2'd2:    ram_wdata = stored_len[7:0];
                    default: ram_wdata = stored_len[15:8];
                endcase
            end
            ST_DONE: begin
                page_we = 1'b1;
                rx_irq  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAGE_W-1:0] ring_first,
    input logic [PAGE_W-1:0] ring_limit,
    input logic              ram_we,
    input logic [PAGE_W+7:0] ram_addr,
    input logic              page_we,
    input logic [PAGE_W-1:0] page_nxt,
    input logic [7:0]        rx_status,
    input logic              rx_irq
);

    // R5: every write lands inside the ring
    a_r5_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr >= {ring_first, 8'h00} && ram_addr < {ring_limit, 8'h00}));

    // R7: the published page lies inside the ring
    a_r7_page_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |-> (page_nxt >= ring_first && page_nxt < ring_limit));

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R6: interrupt follows a header write
    a_r6_header_before_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(ram_we));

    // R9: status holds a legal code after a store
    a_r9_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> (rx_status == 8'h01 || rx_status == 8'h21));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_first (ring_first),
    .ring_limit (ring_limit),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .page_we    (page_we),
    .page_nxt   (page_nxt),
    .rx_status  (rx_status),
    .rx_irq     (rx_irq)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/100ps
module test_rx_ring_writer;

    localparam int PW = 8;
    localparam logic [47:0] STATION = 48'h55_44_33_22_11_02;
    localparam int FIRST = 'h40;
    localparam int LIMIT = 'h46;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0, frm_sof = 1'b0, frm_eof = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic [PW-1:0] cur_pg = PW'(FIRST);
    logic cfg_promisc = 1'b0, cfg_bcast = 1'b0, stopped = 1'b0;
    logic ram_we, page_we, rx_irq;
    logic [PW+7:0] ram_addr;
    logic [7:0] ram_wdata, rx_status;
    logic [PW-1:0] page_nxt;

    always #2.5 clk = ~clk;   // 200 MHz

    rx_ring_writer #(.PAGE_W(PW)) i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .frm_valid(frm_valid), .frm_sof(frm_sof), .frm_eof(frm_eof), .frm_data(frm_data),
        .ring_first(PW'(FIRST)), .ring_limit(PW'(LIMIT)), .cur_page(cur_pg),
        .cfg_promisc(cfg_promisc), .cfg_bcast(cfg_bcast),
        .station_addr(STATION), .stopped(stopped),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .page_we(page_we), .page_nxt(page_nxt),
        .rx_status(rx_status), .rx_irq(rx_irq)
    );

    typedef struct { int a; int d; int r; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int last_page = 0;
    bit done = 0;

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: compares each RAM write with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ram_we) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5/R11: unexpected write addr %h data %h, expected none", ram_addr, ram_wdata);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(ram_addr) == e.a && int'(ram_wdata) == e.d,
                          $sformatf("R%0d: write addr %h data %h, expected addr %h data %h",
                                    e.r, ram_addr, ram_wdata, e.a, e.d));
                end
            end
            if (rx_irq) irq_cnt++;
            if (page_we) begin
                last_page = int'(page_nxt);
                cur_pg <= page_nxt;
            end
        end
    end

    function automatic bit model_accept(input logic [7:0] fb[], input int n);
        logic [47:0] d;
        if (stopped) return 0;               // R1
        if (n < 6) return 0;                 // R10
        for (int i = 0; i < 6; i++) d[8*i +: 8] = fb[i];
        if (cfg_promisc) return 1;           // R2
        if (d == 48'hffff_ffff_ffff) return cfg_bcast;  // R3
        if (d[0]) return 1;                  // R4 group
        return d == STATION;                 // R4 station
    endfunction

    task automatic run_frame(input int n, input logic [47:0] dest, input int seed,
                             input bit junk, input string tag);
        logic [7:0] fb[];
        bit acc;
        int c, nx, p, slen, irq0;
        logic [7:0] st0, st;
        fb = new[n];
        for (int i = 0; i < n; i++)
            fb[i] = (i < 6) ? dest[8*i +: 8] : 8'(i * 7 + seed);
        acc  = model_accept(fb, n);
        c    = int'(cur_pg);
        slen = n + 4;
        nx   = c + (slen + 4 + 255) / 256;                 // R7
        if (nx >= LIMIT) nx = nx - (LIMIT - FIRST);
        st   = (n > 0 && fb[0][0]) ? 8'h21 : 8'h01;         // R9
        st0  = rx_status;
        irq0 = irq_cnt;
        if (acc) begin
            p = c * 256 + 4;                                // R5 data
            for (int i = 0; i < n; i++) begin
                exp_q.push_back('{a: p, d: int'(fb[i]), r: 5});
                p++;
                if (p == LIMIT * 256) p = FIRST * 256;
            end
            exp_q.push_back('{a: c*256,   d: int'(st),          r: 6});  // R6 header
            exp_q.push_back('{a: c*256+1, d: nx,                r: 6});
            exp_q.push_back('{a: c*256+2, d: slen & 8'hff,      r: 6});
            exp_q.push_back('{a: c*256+3, d: (slen >> 8) & 8'hff, r: 6});
        end
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            frm_valid = 1'b1; frm_sof = (i == 0); frm_eof = (i == n - 1); frm_data = fb[i];
        end
        if (junk) begin
            // R11: a new start marker while the block drains the previous frame
            for (int i = 0; i < 3; i++) begin
                @(posedge clk); #1;
                frm_valid = 1'b1; frm_sof = (i == 0); frm_eof = (i == 2);
                frm_data = (i == 0) ? 8'h02 : 8'(8'h80 + i);
            end
        end
        @(posedge clk); #1;
        frm_valid = 1'b0; frm_sof = 1'b0; frm_eof = 1'b0;
        repeat (24) @(negedge clk);
        check(exp_q.size() == 0, $sformatf("R5 %s: %0d expected writes missing, expected 0",
                                           tag, exp_q.size()));
        exp_q.delete();
        check(irq_cnt - irq0 == (acc ? 1 : 0),
              $sformatf("R8 %s: %0d interrupts, expected %0d", tag, irq_cnt - irq0, acc ? 1 : 0));
        if (acc) begin
            check(last_page == nx, $sformatf("R7 %s: page %h, expected %h", tag, last_page, nx));
            check(rx_status == st, $sformatf("R9 %s: status %h, expected %h", tag, rx_status, st));
        end else begin
            check(rx_status == st0, $sformatf("R9 %s: status %h changed on drop, expected %h",
                                              tag, rx_status, st0));
            check(int'(cur_pg) == c, $sformatf("R1 %s: page %h moved on drop, expected %h",
                                               tag, cur_pg, c));
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(ram_we == 0 && page_we == 0 && rx_irq == 0 && rx_status == 8'h00,
              $sformatf("R12: we %b pwe %b irq %b status %h, expected 0 0 0 00",
                        ram_we, page_we, rx_irq, rx_status));

        run_frame(60,  STATION,          1, 0, "R4 station unicast");
        run_frame(60,  48'hffff_ffff_ffff, 2, 0, "R3 broadcast refused");
        cfg_bcast = 1'b1;
        run_frame(60,  48'hffff_ffff_ffff, 3, 0, "R3 broadcast accepted");
        cfg_bcast = 1'b0;
        run_frame(100, 48'h00_00_00_5e_00_01, 4, 0, "R4 group address");
        run_frame(64,  48'h66_55_44_33_22_02, 5, 0, "R4 mismatch dropped");
        cfg_promisc = 1'b1;
        run_frame(64,  48'h66_55_44_33_22_02, 6, 0, "R2 promiscuous");
        cfg_promisc = 1'b0;
        stopped = 1'b1;
        run_frame(60,  STATION,          7, 0, "R1 stopped");
        stopped = 1'b0;
        run_frame(4,   STATION,          8, 0, "R10 short frame");
        cur_pg = PW'('h45);
        run_frame(300, STATION,          9, 0, "R5 data wrap");
        cur_pg = PW'('h44);
        run_frame(500, STATION,         10, 0, "R7 next page wraps");
        run_frame(70,  STATION,         11, 1, "R11 start ignored when busy");
        run_frame(6,   STATION,         12, 0, "R10 six-byte frame");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule